// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block runs the receive side of a single channel of a frame controller. Received octets are stored into buffers that software provides through a ring of descriptors in external memory. Each descriptor is eight bytes long. The layout is fixed:

- byte offset 0: a control/status word
- byte offset 2: a length word
- byte offset 4: the buffer pointer high half
- byte offset 6: the buffer pointer low half

The engine claims a descriptor only when software has set its ownership bit. It fills the buffer byte by byte from a handshaked byte stream. It then hands the descriptor back by writing the length word and, last of all, the status word with ownership cleared.

A frame may spread over several buffers. A buffer that is not the last in its frame is closed when it reaches the configured maximum buffer length. Only the buffer that ends the frame carries:

- the last-in-frame flag,
- the total octet count of the frame,
- the error flags that came with the frame end.

The first buffer of every frame carries a first-in-frame flag. The ring length is defined by the wrap bit of the final descriptor. After that descriptor the engine returns to the ring base.

If the next descriptor is still owned by software, the engine withholds its ready signal and polls the same descriptor until ownership returns. A ring whose base descriptor already carries the wrap bit, or a zero maximum length, is rejected. In that case the engine halts with a configuration-error flag.

Top module: `rxbd_ring_engine`

## Requirements
- R1: Memory accesses use byte addresses and 16-bit words. A request holds its address, direction and data stable until it is acknowledged. The status word is at descriptor offset 0, the length at offset 2, and the pointer at offsets 4 (bits 31:16) and 6 (bits 15:0). Data byte k is written to pointer+k. Even addresses use the upper lane (mem_be=2'b10, wdata[15:8]) and odd addresses the lower lane (2'b01).
- R2: When a fetched status word has the ownership bit (vector bit 15) at 0, the engine accepts no byte (rx_ready=0). It keeps re-reading the same descriptor and does not advance. Once the bit reads 1, reception continues into that descriptor.
- R3: A buffer is handed back in a fixed order: all data bytes are written first, then the length word, then the status word. The status word is written with bit 15 cleared.
- R4: After a descriptor whose wrap bit (vector bit 13) is 1, the next descriptor used is the one at cfg_ring_base. Otherwise the next descriptor is at the current address plus 8.
- R5: A buffer that is not the last in its frame is closed after cfg_max_len bytes. Its length word is cfg_max_len and its last flag (vector bit 11) is 0.
- R6: The buffer holding the byte marked rx_last has its last flag set, and its length word holds the total octet count of the frame. The rx_err bits {lg,no,ab,cr} go to vector bits 5, 4, 3 and 2 of that buffer only. If a byte both ends the frame and fills the buffer, the buffer is treated as last.
- R7: The first-in-frame flag (vector bit 10) is 1 in the first buffer of each frame and 0 in the buffers that continue that frame.
- R8: When a buffer's status word is written back, evt_buf_used pulses for one cycle if that descriptor's interrupt bit (vector bit 12) was 1. evt_frame_rx pulses when that buffer ends a frame, regardless of the interrupt bit.
- R9: In the written status word, the wrap, interrupt and two user-owned bits (vector bits 13, 12, 9, 7) keep their fetched values. Reserved bits 14, 8, 6, 1 and 0 are written as 0.
- R10: If the descriptor at the ring base has its wrap bit set, or cfg_max_len is 0, cfg_err goes to 1. No byte is accepted and no write is made.
- R11: After reset, mem_req, rx_ready, cfg_err and both event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Starts the ring walk from the base |
| cfg_ring_base | input | 32 | Byte address of the first descriptor |
| cfg_max_len | input | 16 | Maximum bytes per buffer |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_data | input | 8 | Received octet |
| rx_last | input | 1 | Octet ends the frame |
| rx_err | input | 4 | Frame-end errors {lg,no,ab,cr}, valid with rx_last |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte lanes of a write (bit 1 = upper lane) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| evt_buf_used | output | 1 | Buffer released with interrupt bit set |
| evt_frame_rx | output | 1 | Frame-ending buffer released |
| cfg_err | output | 1 | Ring configuration rejected |

## Verification
Two closing conditions can arrive on the same byte: the frame end and the buffer reaching cfg_max_len. The stimulus table provokes this with a frame exactly one buffer long. The check is that the buffer carries the last flag with length equal to the limit, and that the next frame starts in a fresh descriptor with the first flag. A second overlap arises when the wrap back to the ring base meets a base descriptor still owned by software. In that case the bench holds a byte valid and watches that rx_ready stays low and polling stays on the base address. It then returns ownership and checks that the frame lands in the base descriptor.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // status bit positions as vector indices (bit 0 of the word is index 15)
  localparam int unsigned SB_OWN   = 15;
  localparam int unsigned SB_WRAP  = 13;
  localparam int unsigned SB_INT   = 12;
  localparam int unsigned SB_LAST  = 11;
  localparam int unsigned SB_FIRST = 10;
  localparam int unsigned SB_LG    = 5;
  localparam int unsigned SB_NO    = 4;
  localparam int unsigned SB_AB    = 3;
  localparam int unsigned SB_CR    = 2;

  // bits copied through from the fetched status word: wrap, int, two user bits
  localparam logic [15:0] KEEP_MASK = 16'h3280;

  localparam logic [31:0] OFF_LEN  = 32'd2;
  localparam logic [31:0] OFF_PHI  = 32'd4;
  localparam logic [31:0] OFF_PLO  = 32'd6;
  localparam logic [31:0] DESC_SZ  = 32'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ST, S_POLL, S_RD_PHI, S_RD_PLO,
    S_DATA, S_WR_BYTE, S_WR_LEN, S_WR_ST, S_HALT
  } eng_state_e;

  typedef struct packed {
    logic lg;
    logic no;
    logic ab;
    logic cr;
  } frm_err_t;

  function automatic logic [15:0] pack_status(input logic [15:0] fetched,
                                              input logic is_last,
                                              input logic is_first,
                                              input frm_err_t err);
    logic [15:0] w;
    w = fetched & KEEP_MASK;
    w[SB_LAST]  = is_last;
    w[SB_FIRST] = is_first;
    w[SB_LG]    = is_last & err.lg;
    w[SB_NO]    = is_last & err.no;
    w[SB_AB]    = is_last & err.ab;
    w[SB_CR]    = is_last & err.cr;
    return w;
  endfunction

  // big-endian lane select: even byte address uses the upper lane
  function automatic logic [1:0] lane_of(input logic addr_lsb);
    return addr_lsb ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic wrap);
    return wrap ? base : cur + DESC_SZ;
  endfunction

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
  import rxbd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic          stall,
  output logic [AW-1:0] desc_addr,
  output logic          at_base
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       desc_addr <= '0;
    else if (load)    desc_addr <= base;
    else if (advance) desc_addr <= AW'(next_desc(32'(desc_addr), 32'(base), wrap));
  end

  assign at_base = (desc_addr == base);

  p_wrap_to_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !load) |=> (desc_addr == $past(base)));

  p_step_eight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load) |=> (desc_addr == $past(desc_addr) + AW'(8)));

  p_hold_while_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(desc_addr));

endmodule

// File: rtl/rxbd_counters.sv
module rxbd_counters #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_buf,
  input  logic          clr_frame,
  input  logic          inc,
  input  logic [LW-1:0] max_len,
  output logic [LW-1:0] buf_cnt,
  output logic [LW-1:0] frame_cnt,
  output logic          full_next
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_cnt <= '0;
    else if (clr_buf) buf_cnt <= '0;
    else if (inc)     buf_cnt <= buf_cnt + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame_cnt <= '0;
    else if (clr_frame) frame_cnt <= '0;
    else if (inc)       frame_cnt <= frame_cnt + LW'(1);
  end

  // the byte being stored now is the one that fills the buffer
  assign full_next = ((buf_cnt + LW'(1)) == max_len);

  p_buf_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (max_len != '0 && $stable(max_len)) |-> (buf_cnt <= max_len));

  p_frame_covers_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (frame_cnt >= buf_cnt));

endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned LW       = 16,
  parameter int unsigned POLL_GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic [LW-1:0] cfg_max_len,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [3:0]    rx_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          evt_buf_used,
  output logic          evt_frame_rx,
  output logic          cfg_err
);

  localparam int unsigned PW = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP + 1);

  eng_state_e     state_q;
  logic [15:0]    stat_q;
  logic [AW-1:0]  bptr_q;
  logic [7:0]     byte_q;
  logic           last_q;
  frm_err_t       err_q;
  logic           cont_q;     // current buffer continues an open frame
  logic           len_done_q; // length word of current buffer written
  logic [PW-1:0]  poll_q;

  logic [AW-1:0]  desc_addr;
  logic           at_base;
  logic [LW-1:0]  buf_cnt, frame_cnt;
  logic           full_next;

  // named events for the checks
  logic beat_take;
  logic st_fetch_ack;
  logic owned_by_sw;
  logic ring_too_short;
  logic byte_commit;
  logic len_commit;
  logic st_commit;
  logic buf_close;
  logic [AW-1:0] byte_addr;
  logic [LW-1:0] len_word;

  assign beat_take      = (state_q == S_DATA) && rx_valid;
  assign st_fetch_ack   = (state_q == S_RD_ST) && mem_ack;
  assign owned_by_sw    = st_fetch_ack && !mem_rdata[SB_OWN];
  assign ring_too_short = st_fetch_ack && mem_rdata[SB_OWN] && at_base && mem_rdata[SB_WRAP];
  assign byte_commit    = (state_q == S_WR_BYTE) && mem_ack;
  assign len_commit     = (state_q == S_WR_LEN) && mem_ack;
  assign st_commit      = (state_q == S_WR_ST) && mem_ack;
  assign buf_close      = byte_commit && (last_q || full_next);
  assign byte_addr      = bptr_q + AW'(buf_cnt);
  assign len_word       = last_q ? frame_cnt + LW'(0) : buf_cnt;

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (cfg_ring_base),
    .load      ((state_q == S_IDLE) && cfg_enable),
    .advance   (st_commit),
    .wrap      (stat_q[SB_WRAP]),
    .stall     (state_q == S_POLL),
    .desc_addr (desc_addr),
    .at_base   (at_base)
  );

  rxbd_counters #(.LW(LW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_buf   ((state_q == S_RD_PLO) && mem_ack),
    .clr_frame (st_commit && last_q),
    .inc       (byte_commit),
    .max_len   (cfg_max_len),
    .buf_cnt   (buf_cnt),
    .frame_cnt (frame_cnt),
    .full_next (full_next)
  );

  // state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      stat_q     <= '0;
      bptr_q     <= '0;
      byte_q     <= '0;
      last_q     <= 1'b0;
      err_q      <= '0;
      cont_q     <= 1'b0;
      len_done_q <= 1'b0;
      poll_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (cfg_enable) begin
            cont_q  <= 1'b0;
            state_q <= (cfg_max_len == '0) ? S_HALT : S_RD_ST;
          end
        end
        S_RD_ST: begin
          if (mem_ack) begin
            stat_q <= mem_rdata;
            if (!mem_rdata[SB_OWN]) begin
              poll_q  <= PW'(POLL_GAP);
              state_q <= S_POLL;
            end else if (ring_too_short) begin
              state_q <= S_HALT;
            end else begin
              state_q <= S_RD_PHI;
            end
          end
        end
        S_POLL: begin
          if (poll_q == '0) state_q <= S_RD_ST;
          else              poll_q  <= poll_q - PW'(1);
        end
        S_RD_PHI: begin
          if (mem_ack) begin
            bptr_q[AW-1:16] <= mem_rdata[AW-17:0];
            state_q         <= S_RD_PLO;
          end
        end
        S_RD_PLO: begin
          if (mem_ack) begin
            bptr_q[15:0] <= mem_rdata;
            len_done_q   <= 1'b0;
            state_q      <= S_DATA;
          end
        end
        S_DATA: begin
          if (rx_valid) begin
            byte_q  <= rx_data;
            last_q  <= rx_last;
            err_q   <= rx_last ? frm_err_t'(rx_err) : '0;
            state_q <= S_WR_BYTE;
          end
        end
        S_WR_BYTE: begin
          if (mem_ack) state_q <= (last_q || full_next) ? S_WR_LEN : S_DATA;
        end
        S_WR_LEN: begin
          if (mem_ack) begin
            len_done_q <= 1'b1;
            state_q    <= S_WR_ST;
          end
        end
        S_WR_ST: begin
          if (mem_ack) begin
            cont_q     <= !last_q;
            last_q     <= 1'b0;
            len_done_q <= 1'b0;
            state_q    <= S_RD_ST;
          end
        end
        S_HALT: begin
          if (!cfg_enable) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 2'b11;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (state_q)
      S_RD_ST:  mem_req = 1'b1;
      S_RD_PHI: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(OFF_PHI);
      end
      S_RD_PLO: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(OFF_PLO);
      end
      S_WR_BYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = lane_of(byte_addr[0]);
        mem_wdata = {byte_q, byte_q};
      end
      S_WR_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(OFF_LEN);
        mem_wdata = 16'(len_word);
      end
      S_WR_ST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pack_status(stat_q, last_q, !cont_q, err_q);
      end
      default: ;
    endcase
  end

  assign rx_ready     = (state_q == S_DATA);
  assign evt_buf_used = st_commit && stat_q[SB_INT];
  assign evt_frame_rx = st_commit && last_q;
  assign cfg_err      = (state_q == S_HALT);

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_no_take_when_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    owned_by_sw |=> !rx_ready);

  p_len_then_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit |-> (len_done_q && !mem_wdata[SB_OWN]));

  p_close_to_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |=> (state_q == S_WR_LEN));

  p_evt_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_buf_used || evt_frame_rx) |-> (mem_we && mem_ack && mem_addr == desc_addr));

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!rx_ready && !mem_req));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit |-> ((mem_wdata & 16'h4143) == 16'h0000));

endmodule

// File: tb/rxbd_ring_engine_tb.sv
module rxbd_ring_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_ring_base = 32'h100;
  logic [15:0] cfg_max_len = 16'd6;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_last = 1'b0;
  logic [3:0]  rx_err = 4'h0;
  logic        mem_req, mem_we;
  logic [1:0]  mem_be;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_ack = 1'b0;
  logic        evt_buf_used, evt_frame_rx, cfg_err;

  always #5 clk = ~clk;

  rxbd_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
    .cfg_max_len(cfg_max_len), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .evt_buf_used(evt_buf_used), .evt_frame_rx(evt_frame_rx), .cfg_err(cfg_err)
  );

  // memory model: 2 KB, one-cycle acknowledge
  logic [15:0] mem [0:1023];
  int n_bufused = 0, n_frmrx = 0, n_basereads = 0, n_writes = 0;
  logic [31:0] last_rd_addr = 32'h0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        n_writes <= n_writes + 1;
        if (mem_be[1]) mem[mem_addr[10:1]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_addr[10:1]][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata    <= mem[mem_addr[10:1]];
        last_rd_addr <= mem_addr;
        if (mem_addr == cfg_ring_base) n_basereads <= n_basereads + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (evt_buf_used) n_bufused <= n_bufused + 1;
    if (evt_frame_rx) n_frmrx <= n_frmrx + 1;
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] bb(input int n);
    return 16'h8000 >> n;   // word bit n in big-endian numbering
  endfunction

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    logic [15:0] w;
    w = mem[a[10:1]];
    return a[0] ? w[7:0] : w[15:8];
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic last, input logic [3:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = e;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 4'h0;
  endtask

  task automatic put_desc(input logic [31:0] base, input int d, input logic [15:0] st);
    logic [31:0] a, b;
    a = base + 32'(8 * d);
    b = 32'h200 + 32'(32 * d);
    mem[a[10:1]]       = st;
    mem[a[10:1] + 1]   = 16'h0000;
    mem[a[10:1] + 2]   = b[31:16];
    mem[a[10:1] + 3]   = b[15:0];
  endtask

  // stimulus table: {frame length, error flags {lg,no,ab,cr}}
  localparam int NF = 5;
  localparam logic [19:0] FRAMES [NF] = '{
    {16'd3,  4'b0000},
    {16'd6,  4'b0000},   // frame end and full buffer on the same byte
    {16'd7,  4'b0000},
    {16'd13, 4'b0000},
    {16'd2,  4'b0011}
  };

  logic [15:0] init_st [8];
  logic [7:0]  seed;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    for (int d = 0; d < 8; d++) begin
      init_st[d] = bb(0) | ((d % 2 == 0) ? bb(3) : 16'h0) | ((d == 7) ? bb(2) : 16'h0);
      if (d == 3) init_st[d] = init_st[d] | bb(1) | bb(7) | bb(9) | bb(14) | bb(15) | bb(6) | bb(8);
      put_desc(32'h100, d, init_st[d]);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 mem_req", {31'd0, mem_req}, 32'd0);
    check("R11 rx_ready", {31'd0, rx_ready}, 32'd0);
    check("R11 events", {30'd0, evt_buf_used, evt_frame_rx}, 32'd0);
    check("R11 cfg_err", {31'd0, cfg_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1;

    // table walk
    seed = 8'h10;
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < int'(FRAMES[f][19:4]); k++) begin
        send_byte(seed, (k == int'(FRAMES[f][19:4]) - 1), FRAMES[f][3:0]);
        seed = seed + 8'd1;
      end
      repeat (30) @(negedge clk);
    end

    // expected model: split frames into buffers of at most 6
    begin
      int d;
      logic [7:0] v;
      d = 0; v = 8'h10;
      for (int f = 0; f < NF; f++) begin
        int left, flen;
        logic [3:0] e;
        flen = int'(FRAMES[f][19:4]);
        e = FRAMES[f][3:0];
        left = flen;
        for (int p = 0; left > 0; p++) begin
          int n;
          logic lst;
          logic [15:0] es;
          logic [31:0] ba;
          n = (left > 6) ? 6 : left;
          lst = (left <= 6);
          es = (init_st[d] & (bb(2) | bb(3) | bb(6) | bb(8)));
          if (lst) es = es | bb(4) | (e[3] ? bb(10) : 16'h0) | (e[2] ? bb(11) : 16'h0)
                          | (e[1] ? bb(12) : 16'h0) | (e[0] ? bb(13) : 16'h0);
          if (p == 0) es = es | bb(5);
          // R3 R5 R6 R7 R9 status; R5 R6 length
          check($sformatf("R3/R7/R9 status d%0d", d), {16'd0, mem[(32'h100 + 32'(8*d)) >> 1]}, {16'd0, es});
          check($sformatf("R5/R6 length d%0d", d), {16'd0, mem[(32'h102 + 32'(8*d)) >> 1]},
                {16'd0, lst ? 16'(flen) : 16'd6});
          ba = 32'h200 + 32'(32 * d);
          begin
            int bad;
            bad = 0;
            for (int k = 0; k < n; k++) begin
              if (rd_byte(ba + 32'(k)) !== v) bad++;
              v = v + 8'd1;
            end
            check($sformatf("R1 data bytes d%0d", d), 32'(bad), 32'd0);
          end
          left = left - n;
          d++;
        end
      end
    end
    check("R8 buffer-used events", 32'(n_bufused), 32'd4);
    check("R8 frame events", 32'(n_frmrx), 32'd5);

    // R2 stall on the software-owned base descriptor after wrap
    begin
      int polls0;
      int seen_ready;
      polls0 = n_basereads;
      seen_ready = 0;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hA5; rx_last = 1'b0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (rx_ready) seen_ready++;
      end
      rx_valid = 1'b0;
      check("R2 no ready while owned", 32'(seen_ready), 32'd0);
      check("R2 re-polls base", 32'(n_basereads > polls0 + 3), 32'd1);
      check("R2 stays on base", last_rd_addr, 32'h100);
      mem[32'h100 >> 1] = bb(0) | bb(3);
      for (int k = 0; k < 4; k++) send_byte(8'hA0 + 8'(k), (k == 3), 4'h0);
      repeat (30) @(negedge clk);
      check("R4 wrap status d0", {16'd0, mem[32'h100 >> 1]}, {16'd0, bb(3) | bb(4) | bb(5)});
      check("R4 wrap length d0", {16'd0, mem[32'h102 >> 1]}, 32'd4);
      check("R1 byte lanes d0", {rd_byte(32'h200), rd_byte(32'h201), rd_byte(32'h202), rd_byte(32'h203)},
            32'hA0A1A2A3);
      check("R8 events after wrap", 32'(n_bufused * 16 + n_frmrx), 32'(5 * 16 + 6));
    end

    // R10 single-descriptor ring rejected
    cfg_enable = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 reset again", {29'd0, mem_req, rx_ready, cfg_err}, 32'd0);
    cfg_ring_base = 32'h180;
    mem[32'h180 >> 1] = bb(0) | bb(2);
    rst_n = 1'b1;
    begin
      int w0, seen;
      w0 = n_writes;
      seen = 0;
      @(negedge clk);
      cfg_enable = 1'b1;
      rx_valid = 1'b1; rx_data = 8'h55;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (rx_ready) seen++;
      end
      rx_valid = 1'b0;
      check("R10 cfg_err", {31'd0, cfg_err}, 32'd1);
      check("R10 no ready", 32'(seen), 32'd0);
      check("R10 no writes", 32'(n_writes - w0), 32'd0);
      check("R10 base untouched", {16'd0, mem[32'h180 >> 1]}, {16'd0, bb(0) | bb(2)});
    end

    // R10 zero length limit
    cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    cfg_ring_base = 32'h100;
    cfg_max_len = 16'd0;
    @(negedge clk);
    cfg_enable = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 zero max length", {31'd0, cfg_err}, 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule